// File: doc/BRIEF.md
# Fractional-N PLL Control and Status Registers

This block is a pair of 32-bit registers that software uses to control a fractional-N PLL. The first word holds the power, bypass, clock-enable and output-divider controls. It also holds the reload handshake bits and a read-only lock flag. The second word stages the integer and fractional feedback divider values. The block drives the analog PLL controls and the currently active divider values onto output ports.

Software writes the new feedback divider values into the second word and then sets the reload request bit. In normal operation the block copies the staged values into the active dividers and raises the acknowledge bit. It then waits for software to drop the request before it clears the acknowledge, so each reload is a full four-phase handshake. When the PLL is powered down or bypassed, no handshake is needed: the active dividers follow the staged values while the request is held, and the acknowledge stays low.

A settle counter stands in for the lock detector. Lock goes low on power-down and on every acknowledged reload. It comes back high after `SETTLE_CYCLES` clock cycles of uninterrupted operation.

Top module: `fpll_csr`

## Requirements
- R1: After reset, word 0 (byte offset 0x0) reads 0x00080000, with only power-down set. Word 1 (byte offset 0x4) reads 0. The active divider outputs are 0 and the lock output is 0.
- R2: In word 0, bit 21 is clock-enable, bit 19 is power-down, bit 14 is bypass, bit 12 is the reload request, and bits 4:0 are the output divider code. These fields read back what was written and drive the matching outputs. Unused bits read 0.
- R3: In word 1, bits 30:7 are the 24-bit fractional feedback value and bits 6:0 are the 7-bit integer feedback value. Both read back as written. Bit 31 reads 0.
- R4: Writing word 1 changes the active divider outputs only when a reload takes place.
- R5: Power-down and bypass are both clear, and the request bit is written to 1 while the acknowledge (word 0 bit 11) is 0. One clock edge later, the active dividers equal the staged values and the acknowledge reads 1. The edge on which the request write lands does not yet change them.
- R6: The acknowledge stays 1 for as long as the request stays 1. It returns to 0 on the clock edge after the one on which the request is cleared.
- R7: With power-down or bypass set, a set request makes the active dividers follow the staged values one edge later. The acknowledge stays 0, and lock is not restarted.
- R8: After power-down is cleared, lock (word 0 bit 31 and the lock output) reads 0 for `SETTLE_CYCLES`-1 edges and 1 from edge `SETTLE_CYCLES` onward.
- R9: Lock drops on the edge that performs an acknowledged reload and returns `SETTLE_CYCLES` edges later. Lock also reads 0 from the second edge after power-down is set.
- R10: Writes to word 0 bits 31 and 11 have no effect on lock or acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pll_pd | output | 1 | Power-down control |
| pll_bypass | output | 1 | Bypass control |
| pll_clk_en | output | 1 | Output clock enable |
| out_div_code | output | 5 | Output divider code; the division is (code+1)*2 |
| act_fbk_int | output | 7 | Active integer feedback value; the multiplier is value+1 |
| act_fbk_frac | output | 24 | Active fractional feedback value, over 2^24 |
| pll_locked | output | 1 | Emulated lock indicator |

## Verification
A write takes effect on the edge on which the strobe is sampled, and a read reflects it straight away because the read path is combinational. The reload copy and the rise of the acknowledge come one edge after the request write. The fall of the acknowledge comes one edge after the request is cleared. The bench samples first after the write edge, to see the unchanged values, and then after one more edge. Lock is due exactly `SETTLE_CYCLES` edges after the power-up write or the reload edge. The bench counts edges and checks lock both one edge before and on the due edge.

// File: rtl/fpll_pkg.sv
package fpll_pkg;
  localparam int DATA_W   = 32;
  localparam int FRAC_W   = 24;
  localparam int INT_W    = 7;
  localparam int ODIV_W   = 5;
  localparam int FRAC_LSB = 7;
  localparam int B_LOCK   = 31;
  localparam int B_CLKEN  = 21;
  localparam int B_PD     = 19;
  localparam int B_BYP    = 14;
  localparam int B_REQ    = 12;
  localparam int B_ACK    = 11;

  typedef struct packed {
    logic              clken;
    logic              pd;
    logic              byp;
    logic              req;
    logic [ODIV_W-1:0] odiv;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{clken: 1'b0, pd: 1'b1, byp: 1'b0, req: 1'b0, odiv: '0};
endpackage

// File: rtl/fpll_cfg_regs.sv
module fpll_cfg_regs
  import fpll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w0_we,
  input  logic              w1_we,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [INT_W-1:0]  stg_int,
  output logic [FRAC_W-1:0] stg_frac
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [INT_W-1:0]  int_q, int_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              unused_wbit;

  assign unused_wbit = wdata[DATA_W-1];

  always_comb begin
    ctrl_d = ctrl_q;
    int_d  = int_q;
    frac_d = frac_q;
    if (w0_we) begin
      ctrl_d.clken = wdata[B_CLKEN];
      ctrl_d.pd    = wdata[B_PD];
      ctrl_d.byp   = wdata[B_BYP];
      ctrl_d.req   = wdata[B_REQ];
      ctrl_d.odiv  = wdata[ODIV_W-1:0];
    end
    if (w1_we) begin
      int_d  = wdata[INT_W-1:0];
      frac_d = wdata[FRAC_LSB +: FRAC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      int_q  <= '0;
      frac_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      int_q  <= int_d;
      frac_q <= frac_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign stg_int  = int_q;
  assign stg_frac = frac_q;
endmodule

// File: rtl/fpll_reload_ctl.sv
module fpll_reload_ctl
  import fpll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              pd,
  input  logic              byp,
  input  logic [INT_W-1:0]  stg_int,
  input  logic [FRAC_W-1:0] stg_frac,
  output logic              ack,
  output logic              reload_evt,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac
);
  logic              ack_q, ack_d;
  logic [INT_W-1:0]  int_q, int_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              follow;

  assign reload_evt = req & ~ack_q & ~pd & ~byp;
  assign follow     = req & (pd | byp);

  always_comb begin
    ack_d  = req ? (ack_q | reload_evt) : 1'b0;
    int_d  = int_q;
    frac_d = frac_q;
    if (reload_evt || follow) begin
      int_d  = stg_int;
      frac_d = stg_frac;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      int_q  <= '0;
      frac_q <= '0;
    end else begin
      ack_q  <= ack_d;
      int_q  <= int_d;
      frac_q <= frac_d;
    end
  end

  assign ack      = ack_q;
  assign act_int  = int_q;
  assign act_frac = frac_q;
endmodule

// File: rtl/fpll_lock_timer.sv
module fpll_lock_timer #(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic locked
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lk_q, lk_d;

  always_comb begin
    cnt_d = cnt_q;
    lk_d  = lk_q;
    if (restart) begin
      cnt_d = '0;
      lk_d  = 1'b0;
    end else if (!lk_q) begin
      if (cnt_q == CNT_LAST) lk_d = 1'b1;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lk_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lk_q  <= lk_d;
    end
  end

  assign locked = lk_q;
endmodule

// File: rtl/fpll_csr.sv
module fpll_csr
  import fpll_pkg::*;
#(
  parameter int ADDR_W        = 3,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pll_pd,
  output logic              pll_bypass,
  output logic              pll_clk_en,
  output logic [4:0]        out_div_code,
  output logic [6:0]        act_fbk_int,
  output logic [23:0]       act_fbk_frac,
  output logic              pll_locked
);
  localparam int WSEL_W = ADDR_W - 2;

  logic [WSEL_W-1:0] widx;
  logic              hit0, hit1;
  logic [1:0]        unused_abits;
  ctrl_t             ctl;
  logic              ctl_req, rl_ack, reload_evt;
  logic [INT_W-1:0]  stg_int;
  logic [FRAC_W-1:0] stg_frac;

  assign widx         = bus_addr[ADDR_W-1:2];
  assign unused_abits = bus_addr[1:0];
  assign hit0         = (widx == WSEL_W'(0));
  assign hit1         = (widx == WSEL_W'(1));

  fpll_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .w0_we    (bus_we & hit0),
    .w1_we    (bus_we & hit1),
    .wdata    (bus_wdata),
    .ctrl     (ctl),
    .stg_int  (stg_int),
    .stg_frac (stg_frac)
  );

  assign ctl_req = ctl.req;

  fpll_reload_ctl u_reload (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (ctl_req),
    .pd         (ctl.pd),
    .byp        (ctl.byp),
    .stg_int    (stg_int),
    .stg_frac   (stg_frac),
    .ack        (rl_ack),
    .reload_evt (reload_evt),
    .act_int    (act_fbk_int),
    .act_frac   (act_fbk_frac)
  );

  fpll_lock_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctl.pd | reload_evt),
    .locked  (pll_locked)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit0) begin
      bus_rdata[B_LOCK]       = pll_locked;
      bus_rdata[B_CLKEN]      = ctl.clken;
      bus_rdata[B_PD]         = ctl.pd;
      bus_rdata[B_BYP]        = ctl.byp;
      bus_rdata[B_REQ]        = ctl.req;
      bus_rdata[B_ACK]        = rl_ack;
      bus_rdata[ODIV_W-1:0]   = ctl.odiv;
    end else if (hit1) begin
      bus_rdata[INT_W-1:0]          = stg_int;
      bus_rdata[FRAC_LSB +: FRAC_W] = stg_frac;
    end
  end

  assign pll_pd       = ctl.pd;
  assign pll_bypass   = ctl.byp;
  assign pll_clk_en   = ctl.clken;
  assign out_div_code = ctl.odiv;
endmodule

// File: rtl/fpll_csr_chk.sv
module fpll_csr_chk
  import fpll_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pd,
  input logic              byp,
  input logic              locked,
  input logic              req,
  input logic              ack,
  input logic [INT_W-1:0]  act_int,
  input logic [FRAC_W-1:0] act_frac,
  input logic [INT_W-1:0]  stg_int,
  input logic [FRAC_W-1:0] stg_frac
);
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(act_int) && $stable(act_frac)));

  p_ack_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> ($past(req) && !$past(pd) && !$past(byp)));

  p_ack_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> (act_int == $past(stg_int) && act_frac == $past(stg_frac)));

  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req) |=> !ack);

  p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req) |=> ack);

  p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (!pd && !$past(pd)));

  p_lock_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> !locked);

  p_lock_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !locked);
endmodule

bind fpll_csr fpll_csr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pd       (pll_pd),
  .byp      (pll_bypass),
  .locked   (pll_locked),
  .req      (ctl_req),
  .ack      (rl_ack),
  .act_int  (act_fbk_int),
  .act_frac (act_fbk_frac),
  .stg_int  (stg_int),
  .stg_frac (stg_frac)
);

// File: tb/fpll_csr_bench.sv
`timescale 1ns/1ps
module fpll_csr_bench;
  localparam int SETTLE = 64;

  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pll_pd, pll_bypass, pll_clk_en, pll_locked;
  logic [4:0]  out_div_code;
  logic [6:0]  act_fbk_int;
  logic [23:0] act_fbk_frac;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  fpll_csr #(.ADDR_W(3), .SETTLE_CYCLES(SETTLE)) u_fpll_csr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_pd(pll_pd),
    .pll_bypass(pll_bypass), .pll_clk_en(pll_clk_en), .out_div_code(out_div_code),
    .act_fbk_int(act_fbk_int), .act_fbk_frac(act_fbk_frac), .pll_locked(pll_locked)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 word0", v, 32'h0008_0000);
    rd(3'd4, v); chk("R1 word1", v, 32'h0);
    chk("R1 act_int", {25'd0, act_fbk_int}, 32'h0);
    chk("R1 act_frac", {8'd0, act_fbk_frac}, 32'h0);
    chk("R1 locked", {31'd0, pll_locked}, 32'h0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(3'd0, 32'h0028_401F);
    rd(3'd0, v); chk("R2 word0 fields", v, 32'h0028_401F);
    chk("R2 outputs", {pll_clk_en, pll_pd, pll_bypass, out_div_code}, {24'd0, 8'b111_11111});
    wr(3'd0, 32'hFFFF_EFFF);
    rd(3'd0, v); chk("R10 lock/ack bits ignored", v, 32'h0028_401F);
    wr(3'd0, 32'h0008_0005);
    rd(3'd0, v); chk("R2 word0 rewrite", v, 32'h0008_0005);
    chk("R2 odiv out", {27'd0, out_div_code}, 32'h5);
  endtask

  task automatic t_word1();
    logic [31:0] v;
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R3 word1 all ones", v, 32'h7FFF_FFFF);
    chk("R4 act_int unchanged", {25'd0, act_fbk_int}, 32'h0);
    wr(3'd4, 32'h091A_2B2A);
    rd(3'd4, v); chk("R3 word1 pattern", v, 32'h091A_2B2A);
    chk("R4 act_frac unchanged", {8'd0, act_fbk_frac}, 32'h0);
  endtask

  task automatic t_pd_follow();
    logic [31:0] v;
    wr(3'd0, 32'h0008_1000);
    @(negedge clk);
    chk("R7 pd follow int", {25'd0, act_fbk_int}, 32'h2A);
    chk("R7 pd follow frac", {8'd0, act_fbk_frac}, 32'h12_3456);
    rd(3'd0, v); chk("R7 no ack in pd", v, 32'h0008_1000);
    wr(3'd0, 32'h0008_0000);
    wr(3'd4, 32'h0000_0011);
    @(negedge clk);
    chk("R4 no reload without req", {25'd0, act_fbk_int}, 32'h2A);
  endtask

  task automatic t_powerup();
    int start;
    wr(3'd0, 32'h0);
    start = cyc;
    wait_cyc(start + SETTLE - 1);
    chk("R8 not yet locked", {31'd0, pll_locked}, 32'h0);
    wait_cyc(start + SETTLE);
    chk("R8 locked", {31'd0, pll_locked}, 32'h1);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    int start;
    wr(3'd0, 32'h0000_1000);
    chk("R5 not copied on request edge", {25'd0, act_fbk_int}, 32'h2A);
    rd(3'd0, v); chk("R5 ack low on request edge", v, 32'h8000_1000);
    @(negedge clk);
    start = cyc;
    chk("R5 copied int", {25'd0, act_fbk_int}, 32'h11);
    chk("R5 copied frac", {8'd0, act_fbk_frac}, 32'h0);
    rd(3'd0, v); chk("R5 ack set, R9 lock dropped", v, 32'h0000_1800);
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R6 ack held", v, 32'h0000_1800);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R6 ack one edge after clear", v, 32'h0000_0800);
    @(negedge clk);
    rd(3'd0, v); chk("R6 ack cleared", v, 32'h0);
    wait_cyc(start + SETTLE - 1);
    chk("R9 relock not yet", {31'd0, pll_locked}, 32'h0);
    wait_cyc(start + SETTLE);
    chk("R9 relocked", {31'd0, pll_locked}, 32'h1);
  endtask

  task automatic t_bypass();
    logic [31:0] v;
    wr(3'd0, 32'h0000_4000);
    wr(3'd4, 32'h0000_007F);
    wr(3'd0, 32'h0000_5000);
    @(negedge clk);
    chk("R7 bypass follow", {25'd0, act_fbk_int}, 32'h7F);
    rd(3'd0, v); chk("R7 bypass no ack, lock kept", v, 32'h8000_5000);
    wr(3'd0, 32'h0000_4000);
    wr(3'd0, 32'h0008_0000);
    @(negedge clk);
    chk("R9 lock drops on pd", {31'd0, pll_locked}, 32'h0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_word1();
    t_pd_follow();
    t_powerup();
    t_reload();
    t_bypass();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule